// File: doc/BRIEF.md
# SDRAM Bus-Triggered Command Issuer

This block turns ordinary system-bus accesses into single SDRAM maintenance commands. A 3-bit mode input decides how an access to the SDRAM window is handled. Mode 001 (precharge) turns each access into a PRECHARGE. Mode 010 (auto-refresh) turns each access into an AUTO REFRESH. Mode 000 (normal) and every other value let the access finish without any command reaching the SDRAM. Software uses this mainly while bringing the memory up: it selects a mode and then touches an address whose fields name the device, the bank and the scope of the command.

The bus address is packed as {chip, bank, row}. The row field maps directly onto the SDRAM address pins, and its bit 10 is what the device sees on its A10 pin. In precharge mode that bit chooses between closing one bank (A10 low) and closing every bank of the device (A10 high). The block also watches the precharge-to-activate spacing. It has one counter per bank and one whole-device counter for each chip. An ACTIVE request from the neighbouring access engine is held back until the tRP window of the targeted bank has run out. Banks that were not precharged stay available.

Each access takes two bus cycles. The command appears on the SDRAM pins for exactly one clock, and the data-bus output enable is never raised.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While reset is high and in the first cycle after it, every chip select is high, RAS/CAS/WE are high, sd_ba and sd_a are zero, bus_ready is high and act_ready is high.
- R2: An access accepted in mode 001 with row bit 10 low drives PRECHARGE for exactly one clock, in the cycle after acceptance. PRECHARGE is CS low, RAS low, CAS high, WE low. Only the chip select named by the chip field goes low, sd_ba carries the bank field and sd_a carries the row field (so sd_a[10] is 0).
- R3: An access accepted in mode 001 with row bit 10 high drives PRECHARGE with sd_a[10] high and sd_ba forced to zero, whatever the bank field holds.
- R4: An access accepted in mode 010 drives AUTO REFRESH for one clock on the addressed chip only. AUTO REFRESH is CS low, RAS low, CAS low, WE high. sd_ba and sd_a are zero whatever the bank and row fields hold.
- R5: Reads and writes produce the same command. sd_dq_oe stays low in every cycle.
- R6: bus_ready drops for exactly the one cycle after an access is accepted. An access is accepted when bus_sel and bus_ready are both high at a clock edge. bus_resp is always OKAY (2'b00).
- R7: An access accepted in mode 000 or in modes 011 to 111 completes with the normal two-cycle timing and issues no command: all chip selects stay high.
- R8: After a single-bank precharge of chip c, bank b, an ACTIVE to (c, b) is held off until the clock that comes TRP clocks after the PRECHARGE clock. Other banks and other chips are not held off.
- R9: After a precharge of all banks of chip c, an ACTIVE to any bank of chip c is held off for the same TRP-clock window. Other chips are not held off.
- R10: When act_req and act_ready are both high at an edge, the next clock drives ACTIVE (CS low, RAS low, CAS high, WE high) on act_chip, with sd_ba = act_bank and sd_a = act_row. act_ready is low in any cycle in which a command-issuing bus access is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the SDRAM |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Access treatment: 000 normal, 001 precharge, 010 auto-refresh, others none |
| bus_sel | input | 1 | Valid access to the SDRAM window in this address phase |
| bus_write | input | 1 | Access direction; has no effect on the command |
| bus_addr | input | CHIP_W+BANK_W+ROW_W | Access address laid out as {chip, bank, row} |
| bus_ready | output | 1 | Low in the first data cycle of an access |
| bus_resp | output | 2 | Response code, always OKAY |
| act_req | input | 1 | Activate request from the access engine |
| act_chip | input | CHIP_W | Chip targeted by the activate |
| act_bank | input | BANK_W | Bank targeted by the activate |
| act_row | input | ROW_W | Row opened by the activate |
| act_ready | output | 1 | Activate may be taken at this edge |
| sd_cs_n | output | NUM_CHIPS | Active-low chip selects |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_a | output | ROW_W | SDRAM address pins |
| sd_dq_oe | output | 1 | Data-bus output enable |

## Verification
The bench attacks the tRP window from both sides. It sends activates to a bank that has just been precharged on every cycle until one is granted, which catches an off-by-one counter as a grant one cycle early or late. In the same window it hits neighbouring banks and the other chip, so a design that blocked too widely would refuse them. Precharge-all is sent with a nonzero bank field, and refresh with random bank and row bits, so a design that leaked those fields onto sd_ba or sd_a would show wrong pin values. It also issues a bus command and an activate in the same cycle, checks that an access in an unused mode produces no chip select, and uses writes throughout to confirm that the data enable never rises.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

    localparam int A10_IDX = 10;

    localparam logic [2:0] MODE_NORMAL    = 3'b000;
    localparam logic [2:0] MODE_PRECHARGE = 3'b001;
    localparam logic [2:0] MODE_REFRESH   = 3'b010;

    typedef enum logic [2:0] {
        K_NONE,
        K_PRE_ONE,
        K_PRE_ALL,
        K_REFRESH,
        K_ACTIVE
    } cmd_kind_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic cmd_pins_t pins_for(cmd_kind_e k);
        case (k)
            K_PRE_ONE, K_PRE_ALL: pins_for = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            K_REFRESH:            pins_for = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            K_ACTIVE:             pins_for = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            default:              pins_for = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    endfunction

    function automatic cmd_kind_e kind_for_mode(logic [2:0] m, logic a10);
        case (m)
            MODE_PRECHARGE: kind_for_mode = a10 ? K_PRE_ALL : K_PRE_ONE;
            MODE_REFRESH:   kind_for_mode = K_REFRESH;
            default:        kind_for_mode = K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_bus_port.sv
`timescale 1ns/1ps
module sdcmd_bus_port
    import sdcmd_pkg::*;
#(
    parameter int CHIP_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    localparam int ADDR_W = CHIP_W + BANK_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ready,
    output cmd_kind_e         issue_kind,
    output logic [CHIP_W-1:0] f_chip,
    output logic [BANK_W-1:0] f_bank,
    output logic [ROW_W-1:0]  f_row
);
    logic busy;
    logic accept;

    assign f_row     = bus_addr[ROW_W-1:0];
    assign f_bank    = bus_addr[ROW_W +: BANK_W];
    assign f_chip    = bus_addr[ADDR_W-1 -: CHIP_W];
    assign bus_ready = !busy;
    assign accept    = bus_sel && !busy;

    always_comb begin
        issue_kind = K_NONE;
        if (accept)
            issue_kind = kind_for_mode(mode, f_row[A10_IDX]);
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= 1'b0;
        else     busy <= accept;
    end

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_ready) |=> !bus_ready);

    // R6
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |=> bus_ready);

endmodule

// File: rtl/sdcmd_trp_guard.sv
`timescale 1ns/1ps
module sdcmd_trp_guard #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int TRP       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_one,
    input  logic              pre_all,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic [BANK_W-1:0] query_bank,
    output logic              blocked
);
    localparam int CNT_W = $clog2(TRP + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TRP - 1);

    logic [CNT_W-1:0]     all_cnt;
    logic [NUM_BANKS-1:0] bank_blk;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)
                cnt <= '0;
            else if (pre_one && pre_bank == BANK_W'(b))
                cnt <= LOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
        assign bank_blk[b] = (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            all_cnt <= '0;
        else if (pre_all)
            all_cnt <= LOAD;
        else if (all_cnt != '0)
            all_cnt <= all_cnt - 1'b1;
    end

    assign blocked = bank_blk[query_bank] || (all_cnt != '0);

    if (TRP > 1) begin : g_chk
        // R8
        bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
            pre_one |=> bank_blk[$past(pre_bank)]);

        // R9
        all_hold_chk: assert property (@(posedge clk) disable iff (rst)
            pre_all |=> blocked);
    end

endmodule

// File: rtl/sdcmd_pin_drive.sv
`timescale 1ns/1ps
module sdcmd_pin_drive
    import sdcmd_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int CHIP_W    = 1,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_kind_e            kind,
    input  logic [CHIP_W-1:0]    chip,
    input  logic [BANK_W-1:0]    bank,
    input  logic [ROW_W-1:0]     row,
    output logic [NUM_CHIPS-1:0] cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic [BANK_W-1:0]    ba,
    output logic [ROW_W-1:0]     a
);
    cmd_pins_t nxt_pins;
    assign nxt_pins = pins_for(kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n  <= '1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            ba    <= '0;
            a     <= '0;
        end else begin
            cs_n  <= '1;
            ras_n <= nxt_pins.ras_n;
            cas_n <= nxt_pins.cas_n;
            we_n  <= nxt_pins.we_n;
            ba    <= '0;
            a     <= '0;
            if (kind != K_NONE)
                cs_n[chip] <= 1'b0;
            case (kind)
                K_PRE_ONE: begin ba <= bank; a <= row; end
                K_PRE_ALL: a <= row;
                K_ACTIVE:  begin ba <= bank; a <= row; end
                default: ;
            endcase
        end
    end

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R2
    cmd_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && kind == K_NONE) |=> (&cs_n && ras_n));

endmodule

// File: rtl/sdram_cmd_issuer.sv
`timescale 1ns/1ps
module sdram_cmd_issuer
    import sdcmd_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int TRP       = 2,
    localparam int CHIP_W = $clog2(NUM_CHIPS),
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int ADDR_W = CHIP_W + BANK_W + ROW_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           mode,
    input  logic                 bus_sel,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_ready,
    output logic [1:0]           bus_resp,
    input  logic                 act_req,
    input  logic [CHIP_W-1:0]    act_chip,
    input  logic [BANK_W-1:0]    act_bank,
    input  logic [ROW_W-1:0]     act_row,
    output logic                 act_ready,
    output logic [NUM_CHIPS-1:0] sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [ROW_W-1:0]     sd_a,
    output logic                 sd_dq_oe
);
    cmd_kind_e             bus_kind;
    logic [CHIP_W-1:0]     bus_chip;
    logic [BANK_W-1:0]     bus_bank;
    logic [ROW_W-1:0]      bus_row;
    logic [NUM_CHIPS-1:0]  chip_blocked;
    logic                  act_fire;
    cmd_kind_e             sel_kind;
    logic [CHIP_W-1:0]     sel_chip;
    logic [BANK_W-1:0]     sel_bank;
    logic [ROW_W-1:0]      sel_row;

    sdcmd_bus_port #(.CHIP_W(CHIP_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_port (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .bus_sel    (bus_sel),
        .bus_addr   (bus_addr),
        .bus_ready  (bus_ready),
        .issue_kind (bus_kind),
        .f_chip     (bus_chip),
        .f_bank     (bus_bank),
        .f_row      (bus_row)
    );

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        logic hit;
        assign hit = (bus_chip == CHIP_W'(c));
        sdcmd_trp_guard #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .TRP(TRP)) u_guard (
            .clk        (clk),
            .rst        (rst),
            .pre_one    (hit && bus_kind == K_PRE_ONE),
            .pre_all    (hit && bus_kind == K_PRE_ALL),
            .pre_bank   (bus_bank),
            .query_bank (act_bank),
            .blocked    (chip_blocked[c])
        );
    end

    assign act_ready = (bus_kind == K_NONE) && !chip_blocked[act_chip];
    assign act_fire  = act_req && act_ready;

    always_comb begin
        sel_kind = bus_kind;
        sel_chip = bus_chip;
        sel_bank = bus_bank;
        sel_row  = bus_row;
        if (bus_kind == K_REFRESH) begin
            sel_bank = '0;
            sel_row  = '0;
        end
        if (bus_kind == K_NONE) begin
            sel_kind = act_fire ? K_ACTIVE : K_NONE;
            sel_chip = act_chip;
            sel_bank = act_bank;
            sel_row  = act_row;
        end
    end

    sdcmd_pin_drive #(.NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W), .BANK_W(BANK_W),
                      .ROW_W(ROW_W)) u_pins (
        .clk   (clk),
        .rst   (rst),
        .kind  (sel_kind),
        .chip  (sel_chip),
        .bank  (sel_bank),
        .row   (sel_row),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n),
        .ba    (sd_ba),
        .a     (sd_a)
    );

    assign bus_resp = 2'b00;
    assign sd_dq_oe = 1'b0;

    // R5
    write_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_write) |=> !sd_dq_oe);

    // R7
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_ready && mode != MODE_PRECHARGE && mode != MODE_REFRESH && !act_req)
        |=> (&sd_cs_n));

    // R4
    refresh_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_ready && mode == MODE_REFRESH) |=> (sd_a == '0 && sd_ba == '0 && !sd_cas_n));

endmodule

// File: tb/sdram_cmd_issuer_test.sv
`timescale 1ns/1ps
module sdram_cmd_issuer_test;

    localparam int NC  = 2;
    localparam int NB  = 4;
    localparam int RW  = 13;
    localparam int TRP = 3;
    localparam int CW  = 1;
    localparam int BW  = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    mode;
    logic          bus_sel, bus_write;
    logic [CW+BW+RW-1:0] bus_addr;
    logic          bus_ready;
    logic [1:0]    bus_resp;
    logic          act_req;
    logic [CW-1:0] act_chip;
    logic [BW-1:0] act_bank;
    logic [RW-1:0] act_row;
    logic          act_ready;
    logic [NC-1:0] sd_cs_n;
    logic          sd_ras_n, sd_cas_n, sd_we_n;
    logic [BW-1:0] sd_ba;
    logic [RW-1:0] sd_a;
    logic          sd_dq_oe;

    sdram_cmd_issuer #(.NUM_CHIPS(NC), .NUM_BANKS(NB), .ROW_W(RW), .TRP(TRP)) uut (
        .clk(clk), .rst(rst), .mode(mode), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_resp(bus_resp),
        .act_req(act_req), .act_chip(act_chip), .act_bank(act_bank), .act_row(act_row),
        .act_ready(act_ready), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_oe(sd_dq_oe)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // bench model state
    int cur = 0;
    int pre_t [NC][NB];
    bit m_busy = 0;
    logic [NC-1:0] e_cs;
    logic [2:0]    e_cmd;   // {ras_n, cas_n, we_n}
    logic [BW-1:0] e_ba;
    logic [RW-1:0] e_a;
    string         e_tag;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit blocked_m(input int ch, input int bk);
        return (cur + 1) < (pre_t[ch][bk] + TRP);
    endfunction

    task automatic step(input logic sel, input logic wr, input logic [2:0] md,
                        input logic [CW-1:0] ch, input logic [BW-1:0] bk, input logic [RW-1:0] rw,
                        input logic aq, input logic [CW-1:0] ach, input logic [BW-1:0] abk,
                        input logic [RW-1:0] arw);
        bit exp_ready, bus_cmd, exp_aready, acc;
        bus_sel = sel; bus_write = wr; mode = md; bus_addr = {ch, bk, rw};
        act_req = aq; act_chip = ach; act_bank = abk; act_row = arw;
        #1;
        exp_ready = !m_busy;
        acc       = sel && exp_ready;
        bus_cmd   = acc && (md == 3'b001 || md == 3'b010);
        exp_aready = !bus_cmd && !blocked_m(ach, abk);
        check(bus_ready == exp_ready, "R6", "bus_ready", bus_ready, exp_ready);
        check(bus_resp == 2'b00, "R6", "bus_resp", bus_resp, 0);
        check(act_ready == exp_aready, bus_cmd ? "R10" : "R8 R9", "act_ready", act_ready, exp_aready);
        e_cs = '1; e_cmd = 3'b111; e_ba = '0; e_a = '0; e_tag = "R7";
        if (bus_cmd) begin
            e_cs = ~(NC'(1) << ch);
            if (md == 3'b010) begin
                e_cmd = 3'b001; e_tag = "R4";
            end else if (rw[10]) begin
                e_cmd = 3'b010; e_a = rw; e_tag = "R3";
                for (int b = 0; b < NB; b++) pre_t[ch][b] = cur + 1;
            end else begin
                e_cmd = 3'b010; e_a = rw; e_ba = bk; e_tag = "R2";
                pre_t[ch][bk] = cur + 1;
            end
        end else if (aq && exp_aready) begin
            e_cs = ~(NC'(1) << ach); e_cmd = 3'b011; e_ba = abk; e_a = arw; e_tag = "R10";
        end else if (!acc) begin
            e_tag = "R8 R9";
        end
        m_busy = acc;
        @(posedge clk);
        cur++;
        @(negedge clk);
        check(sd_cs_n == e_cs, e_tag, "cs_n", sd_cs_n, e_cs);
        check({sd_ras_n, sd_cas_n, sd_we_n} == e_cmd, e_tag, "ras/cas/we",
              {sd_ras_n, sd_cas_n, sd_we_n}, e_cmd);
        check(sd_ba == e_ba, e_tag, "ba", sd_ba, e_ba);
        check(sd_a == e_a, e_tag, "a", sd_a, e_a);
        check(sd_dq_oe == 1'b0, "R5", "dq_oe", sd_dq_oe, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'b000, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        for (int c = 0; c < NC; c++)
            for (int b = 0; b < NB; b++) pre_t[c][b] = -100;
        rst = 1; bus_sel = 0; bus_write = 0; mode = 0; bus_addr = '0;
        act_req = 0; act_chip = 0; act_bank = 0; act_row = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state, still in reset
        check(sd_cs_n == '1 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "pins in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, '1);
        rst = 0;
        #1;
        check(bus_ready == 1'b1 && act_ready == 1'b1, "R1", "ready after reset",
              {bus_ready, act_ready}, 2'b11);
        check(sd_ba == '0 && sd_a == '0 && !sd_dq_oe, "R1", "addr after reset",
              {sd_ba, sd_a, sd_dq_oe}, 0);

        // R2 single-bank precharge chip0 bank1, then R8 activate retry to same bank
        step(1, 0, 3'b001, 0, 2'd1, 13'h0123 & ~13'h0400, 0, 0, 0, 0);
        step(0, 0, 3'b000, 0, 0, 0, 1, 0, 2'd2, 13'h0aa);   // R8 other bank free
        for (int i = 0; i < TRP + 1; i++)
            step(0, 0, 3'b000, 0, 0, 0, 1, 0, 2'd1, 13'h155); // R8 same bank waits
        // R3 precharge-all on chip1 with nonzero bank field, R9 holds
        step(1, 1, 3'b001, 1, 2'd3, 13'h0400 | 13'h0011, 0, 0, 0, 0);
        step(0, 0, 3'b000, 0, 0, 0, 1, 0, 2'd0, 13'h0321); // R9 chip0 free
        for (int i = 0; i < TRP + 1; i++)
            step(0, 0, 3'b000, 0, 0, 0, 1, 1, 2'd2, 13'h0777); // R9 chip1 waits
        // R4 refresh with write and junk fields
        step(1, 1, 3'b010, 1, 2'd2, 13'h1fff, 0, 0, 0, 0);
        step(1, 0, 3'b010, 0, 2'd1, 13'h0abc, 0, 0, 0, 0);
        idle(1);
        // R7 unused and normal modes
        step(1, 1, 3'b011, 0, 2'd0, 13'h0400, 0, 0, 0, 0);
        idle(1);
        step(1, 0, 3'b000, 1, 2'd3, 13'h0001, 0, 0, 0, 0);
        idle(1);
        step(1, 0, 3'b111, 1, 2'd1, 13'h0000, 0, 0, 0, 0);
        idle(1);
        // R10 bus command and activate in the same cycle
        step(1, 0, 3'b010, 0, 2'd0, 13'h0, 1, 1, 2'd1, 13'h0042);
        step(0, 0, 3'b000, 0, 0, 0, 1, 1, 2'd1, 13'h0042);
        idle(TRP);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [2:0] md;
            r = $urandom_range(0, 9);
            md = (r < 4) ? 3'b001 : (r < 7) ? 3'b010 : (r < 9) ? 3'b000 : 3'($urandom_range(3, 7));
            step($urandom_range(0, 2) == 0, 1'($urandom), md, CW'($urandom), BW'($urandom),
                 RW'($urandom), $urandom_range(0, 1) == 1, CW'($urandom), BW'($urandom),
                 RW'($urandom));
        end
        finish_run();
    end

endmodule